// File: doc/BRIEF.md
# SDRAM command-mode sequencer

This block turns software commands into SDRAM control-pin activity. Software writes a 32-bit command word over a small register bus. The word names an operation, the devices it targets, a refresh repeat count and a mode-register value. The block then drives clock enable, two active-low chip selects, RAS#, CAS#, WE# and the address lines to carry out that operation. It holds a busy flag, readable in a status register, until the operation's timing window has closed. A second register packs the 4-bit timing fields that size those windows.

Software brings a memory up with a fixed order of commands, polling busy between steps: start clock, precharge all, an auto-refresh burst, mode-register load, then normal. Self-refresh and power-down take the devices into low-power states with clock enable held low. A later normal command brings clock enable back, and after self-refresh it also waits out the exit time.

The control is a three-state machine. IDLE drives NOP and waits for an accepted command. ISSUE places the command on the pins for one cycle. WAIT counts the timing window down. The transitions are: IDLE to ISSUE when a command is accepted. ISSUE to WAIT when the window is nonzero. ISSUE to ISSUE, or WAIT to ISSUE, when further auto-refreshes remain. ISSUE to IDLE, or WAIT to IDLE, when the command is complete.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, busy is 0, clock enable is low, both chip selects are high, the pins carry NOP (RAS#, CAS# and WE# all high) with address 0, and every register reads 0.
- R2: A write to bus register 0 while idle is accepted at that clock edge. The command pins appear in the first cycle after the edge, busy reads 1 from that cycle, and register 0 reads back the whole written word. The operation code sits in bits 2:0: 0 normal, 1 start clock, 2 precharge all, 3 auto-refresh, 4 mode load, 5 self-refresh, 6 power-down, 7 no operation.
- R3: A write to register 0 while busy is ignored. The readback keeps the last accepted word and the pin sequence runs on unchanged.
- R4: Bit 4 targets device 1 (sd_cs_n[0]) and bit 3 targets device 2 (sd_cs_n[1]). A targeted device's chip select is low in every cycle, idle cycles included, and an untargeted one is high.
- R5: Start clock raises clock enable from its command cycle, drives NOP and is busy for one cycle.
- R6: Precharge all drives RAS#=0, CAS#=1, WE#=0 with address bit 10 high and all other address bits low. It stays busy for 1+tRP cycles, where tRP is timing bits 23:20.
- R7: Auto-refresh drives RAS#=0, CAS#=0, WE#=1 a total of N+1 times, where N is command bits 8:5. The refreshes are tRC+1 cycles apart (tRC is timing bits 15:12), and busy lasts (N+1)(tRC+1) cycles.
- R8: Mode load drives RAS#, CAS# and WE# all low, with the address lines equal to command bits 21:9. It stays busy for 1+tMRD cycles, where tMRD is timing bits 3:0.
- R9: Self-refresh drives the refresh pin code with clock enable low in the same cycle. Clock enable then stays low, and busy lasts one cycle.
- R10: Power-down drives NOP with clock enable low. Clock enable stays low afterwards, and busy lasts one cycle.
- R11: Normal raises clock enable. When it leaves self-refresh it stays busy for 1+tXSR cycles, where tXSR is timing bits 7:4. Otherwise it is busy for one cycle.
- R12: Bus register 2 reads busy at bit 5 and zero elsewhere. Register 1 reads back the timing word, and register 3 reads 0.
- R13: Every cycle that is not a command cycle carries NOP with address 0. Code 7 issues only a NOP cycle and leaves clock enable unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 command, 1 timing, 2 status, 3 none |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, bit 0 device 1, bit 1 device 2 |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines |

## Verification
A command word accepted at one rising edge shows on the pins and on the busy flag in the very next cycle. Each later busy cycle follows one per edge for exactly the window the timing fields give, so a precharge with tRP=2 covers three cycles. The bench model pushes one expected entry per busy cycle when it accepts a command and pops one entry at every edge. It compares all outputs 5 ns after each rising edge, so every result is checked in the cycle it is due and never one edge early or late. Register reads are combinational and are checked in the same sampling slot.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        MD_NORMAL = 3'd0,
        MD_CLK_ON = 3'd1,
        MD_PALL   = 3'd2,
        MD_AREF   = 3'd3,
        MD_LMR    = 3'd4,
        MD_SREF   = 3'd5,
        MD_PDOWN  = 3'd6,
        MD_RSVD   = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    // pin code {ras_n, cas_n, we_n}
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t PC_NOP  = '{1'b1, 1'b1, 1'b1};
    localparam pin_cmd_t PC_PALL = '{1'b0, 1'b1, 1'b0};
    localparam pin_cmd_t PC_AREF = '{1'b0, 1'b0, 1'b1};
    localparam pin_cmd_t PC_LMR  = '{1'b0, 1'b0, 1'b0};

    // command word layout
    localparam int unsigned DEV2_BIT = 3;
    localparam int unsigned DEV1_BIT = 4;
    localparam int unsigned NRFS_LSB = 5;
    localparam int unsigned MRV_LSB  = 9;
    localparam int unsigned BUSY_BIT = 5;
    localparam int unsigned AP_BIT   = 10;

    // timing field slots (slot * field width = bit offset)
    localparam int unsigned TS_MRD = 0;
    localparam int unsigned TS_XSR = 1;
    localparam int unsigned TS_RC  = 3;
    localparam int unsigned TS_RP  = 5;

endpackage

// File: rtl/sdram_seq_regs.sv
module sdram_seq_regs
    import sdram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned NRFS_W = 4,
    parameter int unsigned TF_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [31:0]       wdata,
    input  logic              busy,
    output logic              start,
    output mode_e             mode,
    output logic              dev1,
    output logic              dev2,
    output logic [NRFS_W-1:0] nrfs,
    output logic [ADDR_W-1:0] mrv,
    output logic [TF_W-1:0]   t_mrd,
    output logic [TF_W-1:0]   t_xsr,
    output logic [TF_W-1:0]   t_rc,
    output logic [TF_W-1:0]   t_rp,
    output logic [31:0]       cmd_word,
    output logic [31:0]       rdata
);

    logic [31:0] cmd_q;
    logic [31:0] tim_q;

    assign start = wr_en && (sel == 2'd0) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            tim_q <= '0;
        end else begin
            if (start)
                cmd_q <= wdata;
            if (wr_en && (sel == 2'd1))
                tim_q <= wdata;
        end
    end

    assign mode     = mode_e'(cmd_q[2:0]);
    assign dev1     = cmd_q[DEV1_BIT];
    assign dev2     = cmd_q[DEV2_BIT];
    assign nrfs     = cmd_q[NRFS_LSB +: NRFS_W];
    assign mrv      = cmd_q[MRV_LSB +: ADDR_W];
    assign t_mrd    = tim_q[TS_MRD*TF_W +: TF_W];
    assign t_xsr    = tim_q[TS_XSR*TF_W +: TF_W];
    assign t_rc     = tim_q[TS_RC*TF_W +: TF_W];
    assign t_rp     = tim_q[TS_RP*TF_W +: TF_W];
    assign cmd_word = cmd_q;

    always_comb begin
        unique case (sel)
            2'd0:    rdata = cmd_q;
            2'd1:    rdata = tim_q;
            2'd2:    rdata = 32'(busy) << BUSY_BIT;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_seq_pkg::*;
#(
    parameter int unsigned NRFS_W = 4,
    parameter int unsigned TF_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mode_e             mode,
    input  logic [NRFS_W-1:0] nrfs,
    input  logic [TF_W-1:0]   t_mrd,
    input  logic [TF_W-1:0]   t_xsr,
    input  logic [TF_W-1:0]   t_rc,
    input  logic [TF_W-1:0]   t_rp,
    output state_e            state,
    output logic              busy,
    output logic              cke
);

    state_e            state_q, state_d;
    logic [TF_W-1:0]   cnt_q;
    logic [NRFS_W-1:0] done_q;
    logic              cke_q;
    logic              sref_q;
    logic [TF_W-1:0]   win;
    logic              more_refs;

    // wait window (field value) after the current command cycle
    always_comb begin
        unique case (mode)
            MD_PALL:   win = t_rp;
            MD_AREF:   win = t_rc;
            MD_LMR:    win = t_mrd;
            MD_NORMAL: win = sref_q ? t_xsr : '0;
            default:   win = '0;
        endcase
    end

    assign more_refs = (mode == MD_AREF) && (done_q != nrfs);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: begin
                if (win != '0)
                    state_d = ST_WAIT;
                else if (more_refs)
                    state_d = ST_ISSUE;
                else
                    state_d = ST_IDLE;
            end
            ST_WAIT: begin
                if (cnt_q != '0)
                    state_d = ST_WAIT;
                else if (more_refs)
                    state_d = ST_ISSUE;
                else
                    state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= '0;
            cke_q   <= 1'b0;
            sref_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start)
                done_q <= '0;
            else if (state_q != ST_IDLE && state_d == ST_ISSUE)
                done_q <= done_q + NRFS_W'(1);
            if (state_q == ST_ISSUE)
                cnt_q <= win - TF_W'(1);
            else if (state_q == ST_WAIT && cnt_q != '0)
                cnt_q <= cnt_q - TF_W'(1);
            if (state_q == ST_ISSUE) begin
                unique case (mode)
                    MD_NORMAL, MD_CLK_ON: begin
                        cke_q  <= 1'b1;
                        sref_q <= 1'b0;
                    end
                    MD_SREF: begin
                        cke_q  <= 1'b0;
                        sref_q <= 1'b1;
                    end
                    MD_PDOWN: cke_q <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        cke = cke_q;
        if (state_q == ST_ISSUE) begin
            unique case (mode)
                MD_NORMAL, MD_CLK_ON: cke = 1'b1;
                MD_SREF, MD_PDOWN:    cke = 1'b0;
                default:              cke = cke_q;
            endcase
        end
    end

    assign state = state_q;
    assign busy  = (state_q != ST_IDLE);

endmodule

// File: rtl/sdram_seq_pins.sv
module sdram_seq_pins
    import sdram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  state_e            state,
    input  mode_e             mode,
    input  logic              dev1,
    input  logic              dev2,
    input  logic [ADDR_W-1:0] mrv,
    output logic [1:0]        cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);

    pin_cmd_t pc;

    always_comb begin
        pc   = PC_NOP;
        addr = '0;
        if (state == ST_ISSUE) begin
            unique case (mode)
                MD_PALL: begin
                    pc           = PC_PALL;
                    addr[AP_BIT] = 1'b1;
                end
                MD_AREF, MD_SREF: pc = PC_AREF;
                MD_LMR: begin
                    pc   = PC_LMR;
                    addr = mrv;
                end
                default: pc = PC_NOP;
            endcase
        end
    end

    assign ras_n = pc.ras_n;
    assign cas_n = pc.cas_n;
    assign we_n  = pc.we_n;
    assign cs_n  = {~dev2, ~dev1};

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned NRFS_W = 4,
    parameter int unsigned TF_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sd_cke,
    output logic [1:0]        sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr
);

    logic              start;
    logic              busy;
    mode_e             mode;
    state_e            state;
    logic              dev1, dev2;
    logic [NRFS_W-1:0] nrfs;
    logic [ADDR_W-1:0] mrv;
    logic [TF_W-1:0]   t_mrd, t_xsr, t_rc, t_rp;
    logic [31:0]       cmd_word;

    sdram_seq_regs #(.ADDR_W(ADDR_W), .NRFS_W(NRFS_W), .TF_W(TF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .sel(bus_sel),
        .wdata(bus_wdata), .busy(busy), .start(start), .mode(mode),
        .dev1(dev1), .dev2(dev2), .nrfs(nrfs), .mrv(mrv),
        .t_mrd(t_mrd), .t_xsr(t_xsr), .t_rc(t_rc), .t_rp(t_rp),
        .cmd_word(cmd_word), .rdata(bus_rdata)
    );

    sdram_seq_fsm #(.NRFS_W(NRFS_W), .TF_W(TF_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .nrfs(nrfs),
        .t_mrd(t_mrd), .t_xsr(t_xsr), .t_rc(t_rc), .t_rp(t_rp),
        .state(state), .busy(busy), .cke(sd_cke)
    );

    sdram_seq_pins #(.ADDR_W(ADDR_W)) u_pins (
        .state(state), .mode(mode), .dev1(dev1), .dev2(dev2), .mrv(mrv),
        .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
        .addr(sd_addr)
    );

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [1:0]        bus_sel,
    input logic [31:0]       bus_rdata,
    input logic              busy,
    input logic [31:0]       cmd_word,
    input logic              sd_cke,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr
);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sel == 2'd0 && !busy) |=> busy);

    p_ignore_busy_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sel == 2'd0 && busy) |=> $stable(cmd_word));

    p_pall_ap_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]);

    p_cke_fall_in_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> busy);

    p_cke_rise_in_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_cke) |-> busy);

    p_status_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 2'd2) |-> (bus_rdata == (32'(busy) << 5)));

    p_idle_nop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sd_ras_n && sd_cas_n && sd_we_n));

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_rdata(bus_rdata), .busy(busy), .cmd_word(cmd_word),
    .sd_cke(sd_cke), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr)
);

// File: tb/tb_sdram_cmd_seq.sv
`timescale 1ns/1ps
module tb_sdram_cmd_seq;

    localparam int AW = 13;

    typedef struct packed {
        logic          cke;
        logic [2:0]    rcw;
        logic [AW-1:0] addr;
    } ent_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_sel = 2'd2;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          sd_cke;
    logic [1:0]    sd_cs_n;
    logic          sd_ras_n, sd_cas_n, sd_we_n;
    logic [AW-1:0] sd_addr;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R1";
    logic [1:0] rest_sel = 2'd2;

    // reference model state
    ent_t        q[$];
    logic        cke_m = 1'b0;
    logic        sref_m = 1'b0;
    logic [31:0] cmd_m = '0;
    logic [31:0] tm_m = '0;

    always #10 clk = ~clk;

    sdram_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr)
    );

    function automatic ent_t mk(logic c, logic [2:0] p, logic [AW-1:0] a);
        ent_t e;
        e.cke = c; e.rcw = p; e.addr = a;
        return e;
    endfunction

    task automatic pad(int n, logic c);
        for (int i = 0; i < n; i++) q.push_back(mk(c, 3'b111, '0));
    endtask

    task automatic build(logic [31:0] w);
        case (w[2:0])
            3'd0: begin
                q.push_back(mk(1'b1, 3'b111, '0));
                if (sref_m) pad(int'(tm_m[7:4]), 1'b1);
                cke_m = 1'b1; sref_m = 1'b0;
            end
            3'd1: begin
                q.push_back(mk(1'b1, 3'b111, '0));
                cke_m = 1'b1; sref_m = 1'b0;
            end
            3'd2: begin
                q.push_back(mk(cke_m, 3'b010, AW'(1) << 10));
                pad(int'(tm_m[23:20]), cke_m);
            end
            3'd3: begin
                for (int k = 0; k <= int'(w[8:5]); k++) begin
                    q.push_back(mk(cke_m, 3'b001, '0));
                    pad(int'(tm_m[15:12]), cke_m);
                end
            end
            3'd4: begin
                q.push_back(mk(cke_m, 3'b000, w[21:9]));
                pad(int'(tm_m[3:0]), cke_m);
            end
            3'd5: begin
                q.push_back(mk(1'b0, 3'b001, '0));
                cke_m = 1'b0; sref_m = 1'b1;
            end
            3'd6: begin
                q.push_back(mk(1'b0, 3'b111, '0));
                cke_m = 1'b0;
            end
            default: q.push_back(mk(cke_m, 3'b111, '0));
        endcase
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // model update at each edge, comparison 5 ns later
    always begin
        logic was_busy;
        ent_t e;
        logic [31:0] exp_rd;
        @(posedge clk);
        if (!rst_n) begin
            q.delete(); cke_m = 1'b0; sref_m = 1'b0; cmd_m = '0; tm_m = '0;
        end else begin
            was_busy = (q.size() != 0);
            if (was_busy) e = q.pop_front();
            if (bus_we && bus_sel == 2'd1) tm_m = bus_wdata;
            if (bus_we && bus_sel == 2'd0 && !was_busy) begin
                cmd_m = bus_wdata;
                build(bus_wdata);
            end
        end
        #5;
        if (!finished) begin
            e = (q.size() != 0) ? q[0] : mk(cke_m, 3'b111, '0);
            case (bus_sel)
                2'd0:    exp_rd = cmd_m;
                2'd1:    exp_rd = tm_m;
                2'd2:    exp_rd = (q.size() != 0) ? 32'h20 : 32'h0;
                default: exp_rd = '0;
            endcase
            chk(cur_req, "cke", 32'(sd_cke), 32'(e.cke));
            chk(cur_req, "ras/cas/we", 32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'(e.rcw));
            chk(cur_req, "addr", 32'(sd_addr), 32'(e.addr));
            chk("R4", "cs_n", 32'(sd_cs_n), 32'({~cmd_m[3], ~cmd_m[4]}));
            chk("R2 R12", "readback", bus_rdata, exp_rd);
        end
    end

    task automatic wr(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_sel = rest_sel;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state, all registers read 0
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); bus_sel = 2'(s);
        end
        @(negedge clk); bus_sel = 2'd2;
        // R12: timing register write and readback
        cur_req = "R12";
        wr(2'd1, 32'h0121_2531);
        @(negedge clk); bus_sel = 2'd1; @(negedge clk); bus_sel = 2'd3;
        @(negedge clk); bus_sel = 2'd2;
        // R13: command pins before clock start, code 7 is a NOP cycle
        cur_req = "R13";
        wr(2'd0, 32'h0000_0017); wait_idle();
        // R5: start clock, device 1 only
        cur_req = "R5";
        wr(2'd0, 32'h0000_0011); wait_idle();
        // R6: precharge all, both devices
        cur_req = "R6";
        wr(2'd0, 32'h0000_001A); wait_idle();
        // R7: four auto-refreshes
        cur_req = "R7";
        wr(2'd0, 32'h0000_0018 | 32'h3 | (32'd3 << 5)); wait_idle();
        // R8: mode load, CAS latency 3 at bits 6:4, burst code 2 at bits 2:0
        cur_req = "R8";
        wr(2'd0, 32'h0000_0014 | ((32'h32) << 9)); wait_idle();
        // R11: normal without self-refresh is one busy cycle
        cur_req = "R11";
        wr(2'd0, 32'h0000_0018); wait_idle();
        // R3: write while busy is ignored; readback held on register 0
        cur_req = "R3";
        rest_sel = 2'd0;
        wr(2'd0, 32'h0000_0013 | (32'd5 << 5));
        wr(2'd0, 32'h0000_0014 | (32'h7F << 9));
        wait_idle();
        rest_sel = 2'd2; bus_sel = 2'd2;
        // R9: self-refresh device 2, then R11 exit with tXSR window
        cur_req = "R9";
        wr(2'd0, 32'h0000_000D); wait_idle();
        cur_req = "R11";
        wr(2'd0, 32'h0000_0008); wait_idle();
        // R10: power-down, then normal exit without tXSR
        cur_req = "R10";
        wr(2'd0, 32'h0000_0016); wait_idle();
        cur_req = "R11";
        wr(2'd0, 32'h0000_0010); wait_idle();
        // R7/R8 zero windows: tRC=0 and tMRD=0
        cur_req = "R7";
        wr(2'd1, 32'h0121_0530);
        wr(2'd0, 32'h0000_0013 | (32'd2 << 5)); wait_idle();
        cur_req = "R8";
        wr(2'd0, 32'h0000_0014 | (32'h1FFF << 9)); wait_idle();
        // R4: precharge with no device targeted
        cur_req = "R6";
        wr(2'd0, 32'h0000_0002); wait_idle();
        // R2: readback of a full word including unused upper bits
        cur_req = "R2";
        rest_sel = 2'd0;
        wr(2'd0, 32'hA500_0017); wait_idle();
        finish_run();
    end

endmodule